// File: doc/BRIEF.md
# ADC Idle Power-Down Controller

This block owns the power and clock-gating state of an analog-to-digital converter core. A conversion sequencer sends it requests. It answers with a permit that tells the sequencer when sampling may begin. It also drives the core's power-down line. Two register fields choose how that line behaves:

- **Automatic idle mode.** The core is shut off whenever there is no work and woken as soon as work arrives. Each wake is followed by a programmable settling count in bus-clock cycles before sampling is permitted.
- **Manual mode.** The power-down line simply follows a software bit, and no settling count is applied.

A system power controller may ask for the module clock to be stopped. The block acknowledges only when no conversion is running. While the acknowledge is held, new requests wait in the pending slot and receive no permit.

A single pending slot records a request until the sequencer is granted it. The permit is high while that slot is full, the core is settled and no clock-stop acknowledge is held. The sequencer starts one conversion per cycle of permit and raises its busy flag on the next cycle.

Top module: `adc_idle_pwr_ctrl`

## Requirements
- R1: Out of reset the core power-down output is 1, and the permit and acknowledge are 0. With automatic idle mode on, the power-down output is 1 after any clock edge at which there is no request, no pending request and no busy conversion.
- R2: With automatic idle mode on, the manual bit is ignored. The core is powered down when idle even with the manual bit at 0, and kept powered while busy even with the manual bit at 1.
- R3: With automatic idle mode on, a request sampled while the core is powered down drives the power-down output to 0 after that same edge.
- R4: With automatic idle mode on and a settling value N, a request sampled at edge E1 while powered down gives a permit first visible after edge E(N+2). The permit is never high while the core is powered down.
- R5: A settling value of 0 gives the permit on the cycle after the wake cycle, i.e. after edge E2.
- R6: With automatic idle mode off, a request sampled at an edge gives a permit after that same edge, with no settling count.
- R7: With automatic idle mode off, the power-down output equals the manual bit sampled at the previous edge.
- R8: A further request that arrives during the settling count neither restarts nor extends it.
- R9: A clock-stop request made while busy is acknowledged only after the edge at which busy is first sampled low. The acknowledge never rises after an edge at which busy was high.
- R10: While the acknowledge is high, requests are held pending and no permit is given. When the clock-stop request falls, the acknowledge clears after the next edge and the held request is then permitted.
- R11: The permit for a pending request lasts one cycle. The slot empties at the edge where the permit was high, and a request stays pending until that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_idle_pd_en | input | 1 | Automatic idle power-down enable (register field) |
| cfg_manual_pd | input | 1 | Manual power-down bit (register field) |
| cfg_wake_dly | input | DLY_W | Settling count after wake, in bus-clock cycles |
| conv_req_i | input | 1 | Conversion request, one cycle per request |
| conv_busy_i | input | 1 | A conversion is in progress |
| clk_stop_req_i | input | 1 | Request to stop the module clock |
| core_pd_o | output | 1 | Power-down control to the converter core |
| sample_ok_o | output | 1 | Sampling of the pending request may start |
| clk_stop_ack_o | output | 1 | Clock may be stopped |

## Verification
The assertions rely on the sequencer behaving well. It raises busy only on the cycle after a permit. It holds busy until the conversion ends. It never raises busy while the acknowledge is high. The setting fields are also assumed to be steady while a settling count runs.

The stimulus follows these rules:
- Busy rises only on the cycle after a permit was observed.
- Clock-stop requests are made during or after conversions, never in the middle of a permit.
- The settling value changes only while the core is idle.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

    // Registered state held by the top-level power logic
    typedef struct packed {
        logic pd;    // core power-down
        logic pend;  // one request waiting for a permit
    } pwr_state_t;

    localparam pwr_state_t PWR_RESET = '{pd: 1'b1, pend: 1'b0};

    // True when nothing is running, waiting or arriving
    function automatic logic no_work(input logic pend, input logic busy, input logic req);
        return !pend && !busy && !req;
    endfunction

endpackage

// File: rtl/adc_wake_settle.sv
module adc_wake_settle #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bypass_i,  // automatic mode off: always settled
    input  logic             hold_i,    // core is being powered down
    input  logic             load_i,    // core is being woken
    input  logic [DLY_W-1:0] dly_i,
    output logic             ready_o
);
    localparam logic [DLY_W-1:0] ONE = {{(DLY_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [DLY_W-1:0] cnt;
        logic             ready;
    } settle_t;

    settle_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (bypass_i) begin
            s_d.ready = 1'b1;
            s_d.cnt   = '0;
        end else if (hold_i) begin
            s_d.ready = 1'b0;
            s_d.cnt   = '0;
        end else if (load_i) begin
            s_d.ready = 1'b0;
            s_d.cnt   = dly_i;
        end else if (!s_q.ready) begin
            if (s_q.cnt == '0) s_d.ready = 1'b1;
            else               s_d.cnt   = s_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{cnt: '0, ready: 1'b0};
        else        s_q <= s_d;
    end

    assign ready_o = s_q.ready;

    // R8: an in-progress count only ever steps down by one
    assert_settle_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass_i && !hold_i && !load_i && !s_q.ready && s_q.cnt != '0)
        |=> (s_q.cnt == ($past(s_q.cnt) - ONE)));

endmodule

// File: rtl/adc_clkstop_hs.sv
module adc_clkstop_hs (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req_i,
    input  logic busy_i,
    input  logic grant_i,
    output logic ack_o
);
    logic ack_d, ack_q;

    always_comb begin
        // acknowledge only with no conversion running and none being granted
        ack_d = stop_req_i && !busy_i && !grant_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= ack_d;
    end

    assign ack_o = ack_q;

    // R9: acknowledge never appears right after a busy cycle
    assert_ack_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> !$past(busy_i));

endmodule

// File: rtl/adc_idle_pwr_ctrl.sv
module adc_idle_pwr_ctrl
    import adc_pwr_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_idle_pd_en,
    input  logic             cfg_manual_pd,
    input  logic [DLY_W-1:0] cfg_wake_dly,
    input  logic             conv_req_i,
    input  logic             conv_busy_i,
    input  logic             clk_stop_req_i,
    output logic             core_pd_o,
    output logic             sample_ok_o,
    output logic             clk_stop_ack_o
);
    pwr_state_t st_d, st_q;
    logic       ready;
    logic       ack;
    logic       grant;
    logic       wake;
    logic       sleep;

    assign grant = st_q.pend && ready && !ack;

    always_comb begin
        st_d = st_q;
        if (cfg_idle_pd_en)
            st_d.pd = no_work(st_q.pend, conv_busy_i, conv_req_i);
        else
            st_d.pd = cfg_manual_pd;
        st_d.pend = (st_q.pend && !grant) || conv_req_i;
        wake  = cfg_idle_pd_en && st_q.pd && !st_d.pd;
        sleep = cfg_idle_pd_en && st_d.pd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PWR_RESET;
        else        st_q <= st_d;
    end

    adc_wake_settle #(.DLY_W(DLY_W)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .bypass_i(!cfg_idle_pd_en),
        .hold_i  (sleep),
        .load_i  (wake),
        .dly_i   (cfg_wake_dly),
        .ready_o (ready)
    );

    adc_clkstop_hs u_stop (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_req_i(clk_stop_req_i),
        .busy_i    (conv_busy_i),
        .grant_i   (grant),
        .ack_o     (ack)
    );

    assign core_pd_o      = st_q.pd;
    assign sample_ok_o    = grant;
    assign clk_stop_ack_o = ack;

    // R3: a request in automatic mode releases the core on the next edge
    assert_release_on_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_idle_pd_en && core_pd_o && conv_req_i) |=> !core_pd_o);

    // R4: no permit while the core is powered down in automatic mode
    assert_no_permit_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_idle_pd_en && sample_ok_o) |-> !core_pd_o);

    // R10: acknowledge and permit are never high together
    assert_no_permit_in_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stop_ack_o |-> !sample_ok_o);

    // R7: manual mode follows the bit with one cycle of latency
    assert_manual_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_idle_pd_en |=> (core_pd_o == $past(cfg_manual_pd)));

    // R11: a permit empties the pending slot unless a new request arrives
    assert_permit_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_ok_o && !conv_req_i) |=> !sample_ok_o);

endmodule

// File: tb/sim_adc_idle_pwr_ctrl.sv
module sim_adc_idle_pwr_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DLY_W      = 8;
    localparam int WATCHDOG   = 5000;
    localparam int NVEC       = 22;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             idle_en, man_pd, req, busy, stop;
    logic [DLY_W-1:0] dly;
    logic             pd, ok, ack;

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_idle_pwr_ctrl #(.DLY_W(DLY_W)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_idle_pd_en(idle_en),
        .cfg_manual_pd (man_pd),
        .cfg_wake_dly  (dly),
        .conv_req_i    (req),
        .conv_busy_i   (busy),
        .clk_stop_req_i(stop),
        .core_pd_o     (pd),
        .sample_ok_o   (ok),
        .clk_stop_ack_o(ack)
    );

    // {idle_en, man_pd, req, busy, stop, exp_pd, exp_ok, exp_ack, req_id[3:0]}
    // settling value 2 throughout
    localparam logic [11:0] VEC [NVEC] = '{
        12'b10000_100_0001, // R1 idle -> off
        12'b10100_000_0011, // R3 wake
        12'b10000_000_0100, // R4 settling
        12'b10100_000_1000, // R8 extra request mid-count
        12'b10000_010_0100, // R4 permit after E(N+2)
        12'b10010_000_1011, // R11 permit consumed
        12'b10011_000_1001, // R9 stop while busy
        12'b10001_101_1001, // R9 ack after busy low
        12'b10101_001_1010, // R10 request held during ack
        12'b10001_001_1010, // R10
        12'b10001_001_1010, // R10
        12'b10001_001_1010, // R10 settled but no permit
        12'b10000_010_1010, // R10 ack drops, permit
        12'b10010_000_1011, // R11
        12'b11010_000_0010, // R2 busy beats manual 1
        12'b10000_100_0010, // R2 idle beats manual 0
        12'b00000_000_0111, // R7 manual 0
        12'b00100_010_0110, // R6 immediate permit
        12'b00010_000_1011, // R11
        12'b01000_100_0111, // R7 manual 1
        12'b01000_100_0111, // R7
        12'b00000_000_0111  // R7
    };

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s pd/ok/ack actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(input logic i, input logic m, input logic r, input logic b, input logic s);
        idle_en = i; man_pd = m; req = r; busy = b; stop = s;
        @(posedge clk);
        @(negedge clk);
    endtask

    // measure the edge index at which the permit first appears after a wake
    task automatic wake_window(input string tag, input int n);
        int first = -1;
        dly = n[DLY_W-1:0];
        step(1, 0, 0, 0, 0);
        step(1, 0, 1, 0, 0);                       // edge E1
        if (ok) first = 1;
        for (int k = 2; k <= n + 4; k++) begin
            step(1, 0, 0, 0, 0);
            if (ok && first < 0) first = k;
        end
        checks++;
        if (first != n + 2) begin
            failures++;
            $display("FAIL %s first permit edge actual=%0d expected=%0d", tag, first, n + 2);
        end
        step(1, 0, 0, 1, 0);                       // consume
        step(1, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; idle_en = 1'b1; man_pd = 1'b0; req = 1'b0; busy = 1'b0; stop = 1'b0;
        dly = 8'd2;
        repeat (3) @(negedge clk);
        chk("R1 reset", {pd, ok, ack}, 3'b100);
        rst_n = 1'b1;

        for (int v = 0; v < NVEC; v++) begin
            step(VEC[v][11], VEC[v][10], VEC[v][9], VEC[v][8], VEC[v][7]);
            chk($sformatf("R%0d vector %0d", VEC[v][3:0], v), {pd, ok, ack}, VEC[v][6:4]);
        end

        wake_window("R5 zero settling", 0);
        wake_window("R4 long settling", 20);
        wake_window("R4 one settling", 1);

        // R2: manual bit 1 stays ignored once busy ends; core goes off when idle
        step(1, 1, 0, 0, 0);
        chk("R2 idle with manual 1", {pd, ok, ack}, 3'b100);

        // R10: request made during ack gets no permit until ack drops (manual mode)
        step(0, 0, 0, 0, 1);
        chk("R10 ack in manual mode", {pd, ok, ack}, 3'b001);
        step(0, 0, 1, 0, 1);
        chk("R10 held request", {pd, ok, ack}, 3'b001);
        step(0, 0, 0, 0, 0);
        chk("R10 released permit", {pd, ok, ack}, 3'b010);
        step(0, 0, 0, 1, 0);
        chk("R11 slot empty", {pd, ok, ack}, 3'b000);

        summary();
        $finish;
    end
endmodule